// File: doc/BRIEF.md
# Two-Way Write-Back Cache Controller

A unified level-one cache controller for a byte-addressed machine with 32-bit addresses and 32-bit words. It holds 8 KB of data in two ways of 256 sets, with four words per line. Each line carries a tag, a valid flag and a dirty flag. Each set carries one most-recently-used marker that chooses the replacement way. Writes are held in the cache and reach memory only when a modified line is evicted. A write miss first brings the line in, then performs the write.

The processor side takes one request at a time through a valid/ready handshake and answers with a one-cycle response strobe. The memory side has a fixed-timing burst port. The controller pulses a start strobe and waits a fixed access latency. It then moves the line in two beats of two words each. A modified victim is written back in full before the read of the new line starts. On a read miss, the requested word goes to the processor in the cycle after it lands in the array.

Top module: `cache2w_top`

## Requirements
- R1: Address bits 3:2 select the word in a line, bits 11:4 select one of 256 sets, and bits 31:12 form the tag. Bits 1:0 are ignored. Lines with the same set bits and different tags compete for the two ways of that set. Lines with different set bits never disturb each other.
- R2: After reset every line is invalid, req_ready is high, rsp_valid is low and the memory port is idle (mem_start and mem_xfer low). The first access to any address misses.
- R3: A read that hits raises rsp_valid with the stored word in the cycle right after the request is accepted.
- R4: A write that hits spends one cycle on the tag check and one cycle on the array write. rsp_valid is raised in the second cycle after acceptance, and later reads of that word return the new value.
- R5: On a miss the replaced way is always the one not marked most recently used in that set. The marker moves to the accessed way on every read hit, every write and every completed fill.
- R6: A memory access begins with a one-cycle mem_start pulse on a line-aligned mem_addr. Transfer (mem_xfer high) begins exactly MEM_LAT (10) cycles after the pulse. It lasts two cycles: mem_beat 0 carries words 0 and 1, and mem_beat 1 carries words 2 and 3, with the lower-numbered word in bits 31:0 of the 64-bit data.
- R7: On a read miss with a clean or empty victim, rsp_valid comes 12 cycles after acceptance when the word is in beat 0, and 13 cycles after acceptance when it is in beat 1, with the word read from memory.
- R8: A valid dirty victim is written back whole (start, latency, two beats, mem_we high) before the fill's mem_start, which follows in the very next cycle. A read miss then responds 24 or 25 cycles after acceptance. Memory receives the modified line contents.
- R9: A write miss fills the line first and writes it only after the fill has finished, responding 13 cycles after acceptance (clean victim) or 25 cycles after acceptance (dirty victim). The other words of the line hold memory data.
- R10: req_ready is low from the cycle after acceptance until the access has responded. rsp_valid is never high while req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address (word aligned) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Access complete; read data valid for reads |
| rsp_rdata | output | 32 | Read data |
| mem_start | output | 1 | One-cycle pulse starting a memory access |
| mem_we | output | 1 | Current memory access is a writeback |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_xfer | output | 1 | Data transfer cycle |
| mem_beat | output | 1 | Beat number within the transfer |
| mem_wdata | output | 64 | Writeback data, two words |
| mem_rdata | input | 64 | Fill data, two words, sampled in transfer cycles |

## Verification
Each access has a fixed response cycle, counted from the first cycle after acceptance as cycle 0. A read hit answers at cycle 0 and a write hit at cycle 1. A clean miss answers at 12 or 13, depending on which beat holds the word, and a dirty-victim miss answers at 24 or 25. The bench drives at the falling edge and counts falling edges until rsp_valid. It then compares that count with the figure the requirement fixes. On the memory side, the gap from each mem_start to the first transfer cycle is measured against the 10-cycle latency. Writeback contents are checked in the bench's memory model before the evicted line is read again.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB_ACC,
    ST_WB_XFER,
    ST_FILL_ACC,
    ST_FILL_XFER,
    ST_RESP,
    ST_WRITE
  } cache_state_e;

endpackage

// File: rtl/cache2w_ram.sv
module cache2w_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);

  logic [WIDTH-1:0] store_q [DEPTH];

  // Synchronous read, output held while rd_en is low.
  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_addr] <= wr_data;
    if (rd_en) rd_data <= store_q[rd_addr];
  end

endmodule

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 256,
  parameter int TAG_W      = 20,
  localparam int IDX_W     = $clog2(SETS),
  localparam int LINE_W    = LINE_WORDS * WORD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [IDX_W-1:0]      rd_idx,
  input  logic [IDX_W-1:0]      cur_idx,
  input  logic                  fill_done,
  input  logic [TAG_W-1:0]      fill_tag,
  input  logic                  mark_dirty,
  input  logic [LINE_WORDS-1:0] word_we,
  input  logic [LINE_W-1:0]     word_wdata,
  output logic [TAG_W-1:0]      tag_q,
  output logic                  valid_q,
  output logic                  dirty_q,
  output logic [LINE_W-1:0]     line_q
);

  logic [SETS-1:0] valid_r;
  logic [SETS-1:0] dirty_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r <= '0;
      dirty_r <= '0;
    end else begin
      if (fill_done) begin
        valid_r[cur_idx] <= 1'b1;
        dirty_r[cur_idx] <= 1'b0;
      end else if (mark_dirty) begin
        dirty_r[cur_idx] <= 1'b1;
      end
    end
  end

  assign valid_q = valid_r[cur_idx];
  assign dirty_q = dirty_r[cur_idx];

  cache2w_ram #(.WIDTH(TAG_W), .DEPTH(SETS)) u_tag (
    .clk     (clk),
    .rd_en   (rd_en),
    .rd_addr (rd_idx),
    .rd_data (tag_q),
    .wr_en   (fill_done),
    .wr_addr (cur_idx),
    .wr_data (fill_tag)
  );

  for (genvar j = 0; j < LINE_WORDS; j++) begin : g_bank
    cache2w_ram #(.WIDTH(WORD_W), .DEPTH(SETS)) u_data (
      .clk     (clk),
      .rd_en   (rd_en),
      .rd_addr (rd_idx),
      .rd_data (line_q[j*WORD_W +: WORD_W]),
      .wr_en   (word_we[j]),
      .wr_addr (cur_idx),
      .wr_data (word_wdata[j*WORD_W +: WORD_W])
    );
  end

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
  import cache2w_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 256,
  parameter int BEAT_WORDS = 2,
  parameter int MEM_LAT    = 10,
  localparam int BEATS     = LINE_WORDS / BEAT_WORDS,
  localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int BEAT_DW   = BEAT_WORDS * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_rdata,
  output logic               mem_start,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_xfer,
  output logic [BEAT_W-1:0]  mem_beat,
  output logic [BEAT_DW-1:0] mem_wdata,
  input  logic [BEAT_DW-1:0] mem_rdata
);

  localparam int BYTE_OFF = $clog2(WORD_W / 8);
  localparam int WSEL_W   = $clog2(LINE_WORDS);
  localparam int OFF_W    = BYTE_OFF + WSEL_W;
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
  localparam int LAT_W    = $clog2(MEM_LAT + 1);
  localparam int LINE_W   = LINE_WORDS * WORD_W;

  cache_state_e        state_q;
  logic [LAT_W-1:0]    lat_q;
  logic [BEAT_W-1:0]   beat_q;
  logic                wr_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WORD_W-1:0]   wdata_q;
  logic                way_q;
  logic [WORD_W-1:0]   fwd_q;
  logic                fwd_vld_q;
  logic [SETS-1:0]     mru_q;

  logic [IDX_W-1:0]    idx_q;
  logic [TAG_W-1:0]    tag_q;
  logic [WSEL_W-1:0]   wsel_q;
  logic [BEAT_W-1:0]   beat_of_word;
  logic [WSEL_W-1:0]   inbeat;
  logic                unused_lo;

  assign idx_q        = addr_q[OFF_W +: IDX_W];
  assign tag_q        = addr_q[ADDR_W-1 -: TAG_W];
  assign wsel_q       = addr_q[BYTE_OFF +: WSEL_W];
  assign beat_of_word = BEAT_W'(int'(wsel_q) / BEAT_WORDS);
  assign inbeat       = WSEL_W'(int'(wsel_q) % BEAT_WORDS);
  assign unused_lo    = ^addr_q[BYTE_OFF-1:0];

  // Per-way lookup results
  logic [1:0][TAG_W-1:0]      w_tag;
  logic [1:0]                 w_valid;
  logic [1:0]                 w_dirty;
  logic [1:0][LINE_W-1:0]     w_line;
  logic [1:0][LINE_WORDS-1:0] w_we;
  logic [1:0]                 w_fill;
  logic [1:0]                 w_mark;
  logic [LINE_W-1:0]          word_wdata;
  logic [1:0]                 hit_vec;

  logic              accept;
  logic              hit;
  logic              hit_way;
  logic              victim_way;
  logic              victim_dirty;
  logic              lat_last;
  logic              beat_last;
  logic [LINE_W-1:0] sel_line;
  logic [WORD_W-1:0] hit_word;

  assign accept       = req_valid && (state_q == ST_IDLE);
  assign hit          = |hit_vec;
  assign hit_way      = hit_vec[1];
  assign victim_way   = ~mru_q[idx_q];
  assign victim_dirty = w_valid[victim_way] && w_dirty[victim_way];
  assign lat_last     = (lat_q == LAT_W'(MEM_LAT - 1));
  assign beat_last    = (beat_q == BEAT_W'(BEATS - 1));
  assign sel_line     = w_line[hit_way];
  assign hit_word     = sel_line[int'(wsel_q)*WORD_W +: WORD_W];

  // Word write data: fill beat words during transfer, else the stored write data
  for (genvar j = 0; j < LINE_WORDS; j++) begin : g_wdata
    assign word_wdata[j*WORD_W +: WORD_W] =
      (state_q == ST_FILL_XFER) ? mem_rdata[(j % BEAT_WORDS)*WORD_W +: WORD_W] : wdata_q;
  end

  for (genvar w = 0; w < 2; w++) begin : g_way
    for (genvar j = 0; j < LINE_WORDS; j++) begin : g_we
      assign w_we[w][j] = (way_q == 1'(w)) &&
        (((state_q == ST_FILL_XFER) && (beat_q == BEAT_W'(j / BEAT_WORDS))) ||
         ((state_q == ST_WRITE) && (wsel_q == WSEL_W'(j))));
    end

    assign w_fill[w]  = (state_q == ST_FILL_XFER) && beat_last && (way_q == 1'(w));
    assign w_mark[w]  = (state_q == ST_WRITE) && (way_q == 1'(w));
    assign hit_vec[w] = w_valid[w] && (w_tag[w] == tag_q);

    cache2w_way #(
      .WORD_W     (WORD_W),
      .LINE_WORDS (LINE_WORDS),
      .SETS       (SETS),
      .TAG_W      (TAG_W)
    ) u_way (
      .clk        (clk),
      .rst        (rst),
      .rd_en      (accept),
      .rd_idx     (req_addr[OFF_W +: IDX_W]),
      .cur_idx    (idx_q),
      .fill_done  (w_fill[w]),
      .fill_tag   (tag_q),
      .mark_dirty (w_mark[w]),
      .word_we    (w_we[w]),
      .word_wdata (word_wdata),
      .tag_q      (w_tag[w]),
      .valid_q    (w_valid[w]),
      .dirty_q    (w_dirty[w]),
      .line_q     (w_line[w])
    );
  end

  // Control sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      lat_q     <= '0;
      beat_q    <= '0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      way_q     <= 1'b0;
      fwd_q     <= '0;
      fwd_vld_q <= 1'b0;
      mru_q     <= '0;
    end else begin
      fwd_vld_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit) begin
            way_q <= hit_way;
            if (wr_q) begin
              state_q <= ST_WRITE;
            end else begin
              mru_q[idx_q] <= hit_way;
              state_q      <= ST_IDLE;
            end
          end else begin
            way_q   <= victim_way;
            lat_q   <= '0;
            state_q <= victim_dirty ? ST_WB_ACC : ST_FILL_ACC;
          end
        end
        ST_WB_ACC: begin
          if (lat_last) begin
            beat_q  <= '0;
            state_q <= ST_WB_XFER;
          end else begin
            lat_q <= lat_q + LAT_W'(1);
          end
        end
        ST_WB_XFER: begin
          if (beat_last) begin
            lat_q   <= '0;
            state_q <= ST_FILL_ACC;
          end else begin
            beat_q <= beat_q + BEAT_W'(1);
          end
        end
        ST_FILL_ACC: begin
          if (lat_last) begin
            beat_q  <= '0;
            state_q <= ST_FILL_XFER;
          end else begin
            lat_q <= lat_q + LAT_W'(1);
          end
        end
        ST_FILL_XFER: begin
          if (beat_q == beat_of_word) begin
            fwd_q     <= mem_rdata[int'(inbeat)*WORD_W +: WORD_W];
            fwd_vld_q <= !wr_q;
          end
          if (beat_last) begin
            mru_q[idx_q] <= way_q;
            if (wr_q)                                  state_q <= ST_WRITE;
            else if (beat_of_word == BEAT_W'(BEATS-1)) state_q <= ST_RESP;
            else                                       state_q <= ST_IDLE;
          end else begin
            beat_q <= beat_q + BEAT_W'(1);
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        ST_WRITE: begin
          mru_q[idx_q] <= way_q;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Processor side
  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = ((state_q == ST_LOOKUP) && !wr_q && hit) || fwd_vld_q ||
                     (state_q == ST_WRITE);
  assign rsp_rdata = fwd_vld_q ? fwd_q : hit_word;

  // Memory side
  logic in_wb;
  logic in_fill;
  assign in_wb     = (state_q == ST_WB_ACC) || (state_q == ST_WB_XFER);
  assign in_fill   = (state_q == ST_FILL_ACC) || (state_q == ST_FILL_XFER);
  assign mem_start = ((state_q == ST_WB_ACC) || (state_q == ST_FILL_ACC)) && (lat_q == '0);
  assign mem_we    = in_wb;
  assign mem_xfer  = (state_q == ST_WB_XFER) || (state_q == ST_FILL_XFER);
  assign mem_beat  = mem_xfer ? beat_q : '0;
  assign mem_addr  = in_wb   ? {w_tag[way_q], idx_q, {OFF_W{1'b0}}} :
                     in_fill ? {tag_q, idx_q, {OFF_W{1'b0}}} : '0;
  assign mem_wdata = (state_q == ST_WB_XFER) ?
                     w_line[way_q][int'(beat_q)*BEAT_DW +: BEAT_DW] : '0;

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int BEAT_WORDS = 2,
  parameter int MEM_LAT    = 10,
  localparam int BEATS     = LINE_WORDS / BEAT_WORDS,
  localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int OFF_W     = $clog2(WORD_W / 8) + $clog2(LINE_WORDS)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_start,
  input logic              mem_we,
  input logic              mem_xfer,
  input logic [BEAT_W-1:0] mem_beat,
  input logic [ADDR_W-1:0] mem_addr
);

  // Cycles elapsed since the last memory start pulse
  int unsigned since_q;
  always_ff @(posedge clk) begin
    if (rst)                          since_q <= 0;
    else if (mem_start)               since_q <= 1;
    else if (mem_xfer)                since_q <= 0;
    else if (since_q != 0)            since_q <= since_q + 1;
  end

  // R2
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (req_ready && !rsp_valid && !mem_xfer && !mem_start));

  // R10
  rsp_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_start |=> !mem_start);

  // R6
  xfer_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_xfer) |-> (since_q == MEM_LAT));

  // R6
  first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_xfer) |-> (mem_beat == '0));

  // R6
  line_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_xfer |-> (mem_addr[OFF_W-1:0] == '0));

  // R8
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_xfer && mem_we && (mem_beat == BEAT_W'(BEATS-1))) |=> (mem_start && !mem_we && !mem_xfer));

endmodule

bind cache2w_top cache2w_chk #(
  .ADDR_W     (ADDR_W),
  .WORD_W     (WORD_W),
  .LINE_WORDS (LINE_WORDS),
  .BEAT_WORDS (BEAT_WORDS),
  .MEM_LAT    (MEM_LAT)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_start (mem_start),
  .mem_we    (mem_we),
  .mem_xfer  (mem_xfer),
  .mem_beat  (mem_beat),
  .mem_addr  (mem_addr)
);

// File: tb/cache2w_top_tb_top.sv
module cache2w_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_start;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic        mem_xfer;
  logic [0:0]  mem_beat;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int start_cyc = 0;
  bit xfer_prev = 1'b0;

  logic [31:0] mem_model [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cache2w_top dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_start(mem_start), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_xfer(mem_xfer), .mem_beat(mem_beat),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] seed_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0]};
  endfunction

  function automatic logic [31:0] mem_read(input logic [31:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return seed_word(a);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model: fixed-timing burst port, two words per beat
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_start) start_cyc = cyc;
      if (mem_xfer && !xfer_prev) begin
        check(cyc - start_cyc == MEM_LAT, "R6", "start-to-transfer gap",
              32'(cyc - start_cyc), 32'(MEM_LAT));
        check(mem_addr[3:0] == 4'h0, "R6", "line aligned address", mem_addr, {mem_addr[31:4], 4'h0});
      end
      if (mem_xfer) begin
        for (int k = 0; k < 2; k++) begin
          logic [31:0] a;
          a = mem_addr + 32'((int'(mem_beat) * 2 + k) * 4);
          if (mem_we) mem_model[a] = mem_wdata[k*32 +: 32];
          else        mem_rdata[k*32 +: 32] = mem_read(a);
        end
      end
      xfer_prev = mem_xfer;
    end
  end

  // One access: latency counted from the first cycle after acceptance (cycle 0)
  task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                        input int exp_lat, input logic [31:0] exp_data, input string req);
    int  lat;
    bit  ready_seen;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    ready_seen = 1'b0;
    while (!rsp_valid && lat < 200) begin
      if (req_ready) ready_seen = 1'b1;
      @(negedge clk);
      lat++;
    end
    check(lat == exp_lat, req, "response cycle", 32'(lat), 32'(exp_lat));
    if (!wr) check(rsp_rdata == exp_data, req, "read data", rsp_rdata, exp_data);
    check(!ready_seen && !req_ready, "R10", "ready low while busy", {31'd0, ready_seen | req_ready}, 32'd0);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R2", "ready after reset", {31'd0, req_ready}, 32'd1);
    check(!rsp_valid && !mem_xfer && !mem_start, "R2", "idle outputs after reset",
          {29'd0, rsp_valid, mem_xfer, mem_start}, 32'd0);
  endtask

  task automatic t_clean_read_miss();
    access(1'b0, 32'h0000_123C, '0, 13, seed_word(32'h0000_123C), "R7");
    access(1'b0, 32'h0000_2234, '0, 12, seed_word(32'h0000_2234), "R7");
  endtask

  task automatic t_read_hit();
    access(1'b0, 32'h0000_1230, '0, 0, seed_word(32'h0000_1230), "R3");
    access(1'b0, 32'h0000_1234, '0, 0, seed_word(32'h0000_1234), "R3");
  endtask

  task automatic t_write_hit();
    access(1'b1, 32'h0000_1238, 32'hDEAD_0001, 1, '0, "R4");
    access(1'b0, 32'h0000_1238, '0, 0, 32'hDEAD_0001, "R4");
  endtask

  task automatic t_replace();
    // Most recent is the 0x1xxx line, so the 0x2xxx line goes
    access(1'b0, 32'h0000_3230, '0, 12, seed_word(32'h0000_3230), "R5");
    access(1'b0, 32'h0000_1238, '0, 0, 32'hDEAD_0001, "R5");
    access(1'b0, 32'h0000_2234, '0, 12, seed_word(32'h0000_2234), "R5");
  endtask

  task automatic t_dirty_read_miss();
    // Victim is the modified 0x1xxx line
    access(1'b0, 32'h0000_323C, '0, 25, seed_word(32'h0000_323C), "R8");
    check(mem_read(32'h0000_1238) == 32'hDEAD_0001, "R8", "written-back word",
          mem_read(32'h0000_1238), 32'hDEAD_0001);
    check(mem_read(32'h0000_1230) == seed_word(32'h0000_1230), "R8", "written-back clean word",
          mem_read(32'h0000_1230), seed_word(32'h0000_1230));
    access(1'b0, 32'h0000_1238, '0, 13, 32'hDEAD_0001, "R8");
  endtask

  task automatic t_write_miss();
    access(1'b1, 32'h0000_5234, 32'hBEEF_0002, 13, '0, "R9");
    access(1'b0, 32'h0000_5234, '0, 0, 32'hBEEF_0002, "R9");
    access(1'b0, 32'h0000_5230, '0, 0, seed_word(32'h0000_5230), "R9");
    access(1'b0, 32'h0000_1230, '0, 0, seed_word(32'h0000_1230), "R5");
    access(1'b1, 32'h0000_6230, 32'hCAFE_0003, 25, '0, "R9");
    access(1'b0, 32'h0000_6230, '0, 0, 32'hCAFE_0003, "R9");
    check(mem_read(32'h0000_5234) == 32'hBEEF_0002, "R9", "evicted write reached memory",
          mem_read(32'h0000_5234), 32'hBEEF_0002);
  endtask

  task automatic t_index();
    access(1'b0, 32'h0000_1240, '0, 12, seed_word(32'h0000_1240), "R1");
    access(1'b0, 32'h0000_1244, '0, 0, seed_word(32'h0000_1244), "R1");
    access(1'b0, 32'h0000_1247, '0, 0, seed_word(32'h0000_1244), "R1");
    access(1'b0, 32'h0000_1230, '0, 0, seed_word(32'h0000_1230), "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clean_read_miss();
    t_read_hit();
    t_write_hit();
    t_replace();
    t_dirty_read_miss();
    t_write_miss();
    t_index();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule